// File: doc/BRIEF.md
# Four-level priority interrupt controller

This block arbitrates seven interrupt requests for a single-issue CPU: two external pins, two timer overflows, the serial port, the general-purpose pin group and the analog comparator. Each source has its own enable, and one global enable masks all of them. Every source except the comparator is given one of four priority levels from a pair of bits, one in a high-priority register and one in a low-priority register. The comparator is fixed at the lowest level.

Raw flags are registered every cycle. On the last cycle of each instruction the controller polls the registered flags and picks the request with the highest level, breaking ties in favour of the lower vector address. It then emits a one-cycle acknowledge with the vector and level, which the CPU turns into a hardware call. A four-bit in-service record marks which levels are running. A new request is only taken if its level is above every level in service. A return strobe clears the highest marked level. While the CPU reports that the current instruction is a return or a write to the enable or priority registers, vectoring is held off. Nothing is remembered between polls. On acknowledge, timer flags and edge-mode external flags get a clear pulse.

Top module: `intc_prio`

## Requirements
- R1: After reset no level is in service and irq_take is low; the first enabled request at any level is accepted.
- R2: Source index i (0 external A, 1 timer A, 2 external B, 3 timer B, 4 serial, 5 general-purpose, 6 comparator) vectors to address 8*i+3, i.e. 0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh, 0033h.
- R3: The level of source i below 6 is {pri_hi[i], pri_lo[i]} (3 highest); the comparator always has level 0.
- R4: Among accepted requests the highest level wins; at equal level the lower source index (lower vector) wins.
- R5: irq_take is a one-cycle pulse only in a cycle with last_cycle high, and it uses flag_in as registered on the previous clock edge; a flag first raised in the polling cycle is not seen.
- R6: With hold high at a poll, no request is taken; a request that is dropped before the next poll is lost.
- R7: Bit 7 of ie is the global enable and bit i enables source i; a masked source never wins.
- R8: A request is taken only if its level is strictly above every level in service; with level 3 in service nothing is taken.
- R9: On acknowledge the bit for the taken level is set in the in-service record; a reti pulse clears its highest set bit.
- R10: flag_clr[i] pulses with irq_take for the winning source when it is a timer (1, 3) or an external source in edge mode (ext_edge[0] for 0, ext_edge[1] for 2); otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| last_cycle | input | 1 | High in the final cycle of the current instruction |
| hold | input | 1 | Current instruction is a return or enable/priority write |
| reti | input | 1 | Return-from-interrupt strobe |
| ie | input | 8 | Enable register: bit 7 global, bits 6..0 per source |
| pri_lo | input | 6 | Low priority bits for sources 0..5 |
| pri_hi | input | 6 | High priority bits for sources 0..5 |
| flag_in | input | 7 | Raw request flags, one per source |
| ext_edge | input | 2 | Edge mode of external sources 0 and 2 |
| irq_take | output | 1 | Acknowledge pulse |
| vector | output | 16 | Vector address of the winner |
| level | output | 2 | Level of the winner |
| flag_clr | output | 7 | Hardware clear pulse per source flag |

## Verification
The block is built with its default seven sources and four levels, small enough that the bench drives every source at every level alone and every pair of sources under all sixteen level combinations. For each level held in service, every request level is also tried. The expected winner is computed by ranking each request as level times eight plus the inverse of its index. Directed sequences cover the poll timing, the hold-off, masking, the stack pop and the clear pulses under both edge settings.

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        last_cycle,
  input  logic        hold,
  input  logic        reti,
  input  logic [7:0]  ie,
  input  logic [5:0]  pri_lo,
  input  logic [5:0]  pri_hi,
  input  logic [6:0]  flag_in,
  input  logic [1:0]  ext_edge,
  output logic        irq_take,
  output logic [15:0] vector,
  output logic [1:0]  level,
  output logic [6:0]  flag_clr
);
  localparam int N_SRC = 7;
  localparam int N_LVL = 4;

  logic [N_SRC-1:0] flag_q;
  logic [N_LVL-1:0] isv, isv_nxt;
  logic [N_SRC-1:0] req, clr_mask;
  logic             found;
  logic [2:0]       win;
  logic [1:0]       wlvl, top;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_in;

  assign req = flag_q & ie[N_SRC-1:0] & {N_SRC{ie[7]}};

  function automatic logic [1:0] src_lvl(input int i, input logic [5:0] hi, input logic [5:0] lo);
    return (i == N_SRC-1) ? 2'd0 : {hi[i], lo[i]};
  endfunction

  always_comb begin
    found = 1'b0;
    win   = '0;
    wlvl  = '0;
    for (int l = N_LVL-1; l >= 0; l--)
      for (int i = 0; i < N_SRC; i++)
        if (!found && req[i] && src_lvl(i, pri_hi, pri_lo) == 2'(l)) begin
          found = 1'b1;
          win   = 3'(i);
          wlvl  = 2'(l);
        end
  end

  always_comb begin
    top = '0;
    for (int l = 0; l < N_LVL; l++)
      if (isv[l]) top = 2'(l);
  end

  assign irq_take = last_cycle && !hold && found && ((isv == '0) || (wlvl > top));
  assign vector   = 16'(VEC_BASE + VEC_STEP * int'(win));
  assign level    = wlvl;
  assign clr_mask = {3'b000, 1'b1, ext_edge[1], 1'b1, ext_edge[0]};
  assign flag_clr = irq_take ? (clr_mask & (7'd1 << win)) : '0;

  always_comb begin
    isv_nxt = isv;
    if (reti && isv != '0) isv_nxt[top] = 1'b0;
    if (irq_take)          isv_nxt[wlvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) isv <= '0;
    else        isv <= isv_nxt;
endmodule

module intc_prio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        last_cycle,
  input logic        hold,
  input logic        reti,
  input logic [7:0]  ie,
  input logic        irq_take,
  input logic [15:0] vector,
  input logic [1:0]  level,
  input logic [6:0]  flag_clr,
  input logic [3:0]  isv
);
  p_take_on_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (last_cycle && !hold));
  p_global_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie[7] |-> !irq_take);
  p_cmp_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && vector == 16'h0033) |-> (level == 2'd0));
  p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (vector[2:0] == 3'd3 && vector < 16'h0038));
  p_no_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((isv >> level) == 4'd0));
  p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> isv[$past(level)]);
  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_take && isv != 4'd0) |=> ($countones(isv) == $countones($past(isv)) - 1));
  p_clr_with_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != 7'd0) |-> (irq_take && $onehot0(flag_clr)));
endmodule

bind intc_prio intc_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .last_cycle(last_cycle), .hold(hold), .reti(reti),
  .ie(ie), .irq_take(irq_take), .vector(vector), .level(level),
  .flag_clr(flag_clr), .isv(isv)
);

// File: tb/intc_prio_tb.sv
module intc_prio_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, last_cycle = 1'b0, hold = 1'b0, reti = 1'b0;
  logic [7:0] ie = 8'hFF;
  logic [5:0] pri_lo = '0, pri_hi = '0;
  logic [6:0] flag_in = '0;
  logic [1:0] ext_edge = '0;
  logic irq_take;
  logic [15:0] vector;
  logic [1:0] level;
  logic [6:0] flag_clr;

  int n_chk = 0, n_err = 0;
  logic s_take; logic [15:0] s_vec; logic [1:0] s_lvl; logic [6:0] s_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_prio u_dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; last_cycle = 1'b0; hold = 1'b0; reti = 1'b0; flag_in = '0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_lvl(input int i, input int l);
    if (i < 6) begin pri_hi[i] = l[1]; pri_lo[i] = l[0]; end
  endtask

  task automatic poll(input logic [6:0] f, input logic h);
    @(negedge clk); flag_in = f;
    @(negedge clk); last_cycle = 1'b1; hold = h;
    #1; s_take = irq_take; s_vec = vector; s_lvl = level; s_clr = flag_clr;
    @(negedge clk); last_cycle = 1'b0; hold = 1'b0; flag_in = '0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  function automatic int exp_lvl(input int i, input int l);
    return (i == 6) ? 0 : l;
  endfunction

  function automatic logic [6:0] exp_clr(input int i, input logic [1:0] e);
    if (i == 1 || i == 3) return 7'(1 << i);
    if (i == 0 && e[0]) return 7'd1;
    if (i == 2 && e[1]) return 7'd4;
    return 7'd0;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk(irq_take == 1'b0, "R1 reset take", irq_take, 0);
    chk(flag_clr == 7'd0, "R1 reset clr", flag_clr, 0);

    // R2 R3 R10: every source alone at every level and edge setting
    for (int i = 0; i < 7; i++)
      for (int l = 0; l < 4; l++) begin
        do_reset();
        ie = 8'hFF; pri_hi = '0; pri_lo = '0; set_lvl(i, l);
        ext_edge = {l[0], l[0]};
        poll(7'(1 << i), 1'b0);
        chk(s_take == 1'b1, "R1 take after reset", s_take, 1);
        chk(s_vec == 16'(8*i+3), "R2 vector", s_vec, 8*i+3);
        chk(int'(s_lvl) == exp_lvl(i, l), "R3 level", s_lvl, exp_lvl(i, l));
        chk(s_clr == exp_clr(i, ext_edge), "R10 clear", s_clr, exp_clr(i, ext_edge));
      end

    // R4: every pair under every level combination
    for (int i = 0; i < 7; i++)
      for (int j = i + 1; j < 7; j++)
        for (int p = 0; p < 16; p++) begin
          int li, lj, ki, kj, w;
          do_reset();
          pri_hi = '0; pri_lo = '0;
          li = exp_lvl(i, p % 4); lj = exp_lvl(j, p / 4);
          set_lvl(i, li); set_lvl(j, lj);
          ki = li * 8 + (7 - i); kj = lj * 8 + (7 - j);
          w = (ki > kj) ? i : j;
          poll(7'((1 << i) | (1 << j)), 1'b0);
          chk(s_take && s_vec == 16'(8*w+3), "R4 winner", s_vec, 8*w+3);
        end

    // R5: flag raised in the polling cycle is not seen, then seen
    do_reset();
    pri_hi = '0; pri_lo = '0;
    @(negedge clk); flag_in = 7'h10; last_cycle = 1'b1;
    #1; chk(irq_take == 1'b0, "R5 same-cycle flag", irq_take, 0);
    @(negedge clk);
    #1; chk(irq_take == 1'b1 && vector == 16'h0023, "R5 registered flag", vector, 16'h0023);
    @(negedge clk); last_cycle = 1'b0;
    #1; chk(irq_take == 1'b0, "R5 single pulse", irq_take, 0);
    flag_in = '0;

    // R6: hold-off then dropped request is lost; held request is taken later
    do_reset();
    poll(7'h20, 1'b1);
    chk(s_take == 1'b0, "R6 hold", s_take, 0);
    poll(7'h00, 1'b0);
    chk(s_take == 1'b0, "R6 dropped", s_take, 0);
    poll(7'h20, 1'b1);
    chk(s_take == 1'b0, "R6 hold again", s_take, 0);
    poll(7'h20, 1'b0);
    chk(s_take && s_vec == 16'h002B, "R6 after hold", s_vec, 16'h002B);

    // R7: global and per-source masking
    do_reset();
    ie = 8'h7F;
    poll(7'h7F, 1'b0);
    chk(s_take == 1'b0, "R7 global off", s_take, 0);
    ie = 8'hFE;
    pri_hi = '0; pri_lo = '0;
    poll(7'h05, 1'b0);
    chk(s_take && s_vec == 16'h0013, "R7 source masked", s_vec, 16'h0013);
    ie = 8'hFF;

    // R8: preemption against each in-service level
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 4; r++) begin
        do_reset();
        pri_hi = '0; pri_lo = '0; set_lvl(0, s); set_lvl(2, r);
        poll(7'h01, 1'b0);
        poll(7'h04, 1'b0);
        chk(s_take == (r > s), "R8 preempt", s_take, int'(r > s));
      end

    // R9: pop highest in-service level
    do_reset();
    pri_hi = '0; pri_lo = '0; set_lvl(0, 1); set_lvl(1, 3); set_lvl(2, 2);
    poll(7'h01, 1'b0);
    poll(7'h02, 1'b0);
    poll(7'h04, 1'b0);
    chk(s_take == 1'b0, "R9 before pop", s_take, 0);
    pulse_reti();
    poll(7'h04, 1'b0);
    chk(s_take && s_lvl == 2'd2, "R9 after pop", s_lvl, 2);
    pulse_reti();
    pulse_reti();
    set_lvl(2, 0);
    poll(7'h04, 1'b0);
    chk(s_take && s_lvl == 2'd0, "R9 empty after pops", s_take, 1);

    // R10: serial and level-mode external get no clear
    do_reset();
    ext_edge = 2'b00; pri_hi = '0; pri_lo = '0;
    poll(7'h04, 1'b0);
    chk(s_take && s_clr == 7'd0, "R10 level-mode ext", s_clr, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule